// File: doc/BRIEF.md
# Writeback ECC Error-Marking Unit

This unit sits between a first-level data cache and the write port of the second-level cache. A dirty or evicted line leaves the first level as a stream of 64-bit doublewords. Each doubleword carries 8 check bits of a single-error-correcting, double-error-detecting code. The unit decodes every doubleword and sorts it into one of four classes: clean, correctable, raw uncorrectable or already-marked uncorrectable. It then sends the word downstream with one register stage of latency.

Clean and already-marked words go through bit for bit. Correctable words are repaired and re-encoded. A raw uncorrectable word never reaches the second level. It is replaced by a poisoned word: a fixed 52-bit signature plus a 12-bit source identifier, stored with a reserved check-bit pattern so that any later decoder can tell it apart from a fresh double error. The identifier comes from a configuration input that is captured on the first doubleword of each line. Each raw error found sets a sticky status flag, which software clears with a write-one-to-clear pulse.

Top module: `ecm_writeback_marker`

## Requirements
- R1: Check code. Check bit k (k = 0..6) is the XOR of every data bit i whose code position has bit k set. Position(i) is the (i+1)-th integer, counting up from 3, that is not a power of two. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. A word that decodes clean is sent out with its data and check bits unchanged.
- R2: A word with a single flipped bit is sent out with the corrected data. Its check bits are generated afresh from that data. This holds whether the flipped bit is a data bit or a check bit, including check bit 7.
- R3: A raw uncorrectable word (two flipped bits) is sent out as a marked word. Its data is 52'hDEAD0BADF00D5 in bits 63:12 and the line's mark ID in bits 11:0. Its check bits are the R1 code of that data XOR 8'h03.
- R4: A word that is already marked (bits 63:12 equal the signature, check bits equal the R1 code XOR 8'h03) is sent out unchanged and does not set the status flag.
- R5: `raw_err_flag` rises in the cycle after a raw word is accepted. It stays set until a cycle in which `raw_clr` is high, and then reads 0 one cycle later. If a raw word is accepted in the same cycle as `raw_clr`, the flag stays set.
- R6: The mark ID is taken from `mark_id_cfg` on the first word of a line, which is the word after reset or after a word accepted with `in_last`. Changes to `mark_id_cfg` later in the same line do not affect that line.
- R7: `in_ready` is high whenever no output word is pending or `out_ready` is high. A pending output holds its data, check bits and `out_last` stable while `out_ready` is low. Each output word, with `out_last` copied from `in_last`, appears one cycle after its input word is accepted.
- R8: After reset, `out_valid` and `raw_err_flag` are 0 and `in_ready` is 1.
- R9: Every word presented on the output decodes either as clean or as marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_id_cfg | input | 12 | Mark identifier, captured at the start of each line |
| raw_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| in_valid | input | 1 | Input doubleword valid |
| in_ready | output | 1 | Unit can accept an input doubleword |
| in_data | input | 64 | Input doubleword |
| in_chk | input | 8 | Input check bits |
| in_last | input | 1 | Input word is the last of its line |
| out_valid | output | 1 | Output doubleword valid |
| out_ready | input | 1 | Second-level write port accepts the word |
| out_data | output | 64 | Output doubleword |
| out_chk | output | 8 | Output check bits |
| out_last | output | 1 | Output word is the last of its line |
| raw_err_flag | output | 1 | Sticky flag: raw uncorrectable error found |

## Verification
An output word is due on the clock edge after its input is accepted. The status flag is due on that same edge for a raw word, and it drops on the edge after `raw_clr`. The bench keeps a queue of expected words in acceptance order. It compares the output only on transfer cycles, sampling at the falling edge after the registers update, and it follows the stall rules of R7 across random `out_ready` gaps. The flag is checked only after the pipeline has drained, so its one-cycle delay is always over by the time it is sampled.

// File: rtl/ecc_mark_pkg.sv
package ecc_mark_pkg;
    localparam int DW   = 64;
    localparam int CW   = 8;
    localparam int IDW  = 12;
    localparam int POSW = CW - 1;
    localparam int SIGW = DW - IDW;
    localparam int MAXPOS = DW + POSW;

    localparam logic [SIGW-1:0] MARK_SIG  = 52'hDEAD0BADF00D5;
    localparam logic [CW-1:0]   MARK_FLIP = 8'h03;
    localparam logic [POSW-1:0] MARK_SYN  = 7'd3;

    typedef enum logic [1:0] {WC_CLEAN, WC_CORR, WC_RAW, WC_MARKED} word_class_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] chk;
    } cword_t;

    // code position of data bit i: skips 1, 2 and every power of two
    function automatic logic [POSW-1:0] pos_of(int i);
        int p;
        p = i + 3;
        for (int k = 2; k < POSW; k++)
            if (p >= (1 << k)) p++;
        return POSW'(p);
    endfunction

    function automatic logic [CW-1:0] ecc_gen(logic [DW-1:0] d);
        logic [POSW-1:0] acc;
        acc = '0;
        for (int i = 0; i < DW; i++)
            if (d[i]) acc ^= pos_of(i);
        return {^{d, acc}, acc};
    endfunction

    function automatic logic [POSW-1:0] syndrome(cword_t w);
        logic [CW-1:0] g;
        g = ecc_gen(w.data);
        return g[POSW-1:0] ^ w.chk[POSW-1:0];
    endfunction

    function automatic word_class_e classify(cword_t w);
        logic [POSW-1:0] s;
        logic            odd;
        s   = syndrome(w);
        odd = ^{w.data, w.chk};
        if (s == '0 && !odd)
            return WC_CLEAN;
        if (odd)
            return (int'(s) <= MAXPOS) ? WC_CORR : WC_RAW;
        if (s == MARK_SYN && w.data[DW-1:IDW] == MARK_SIG)
            return WC_MARKED;
        return WC_RAW;
    endfunction

    function automatic cword_t mark_word(logic [IDW-1:0] id);
        cword_t m;
        m.data = {MARK_SIG, id};
        m.chk  = ecc_gen(m.data) ^ MARK_FLIP;
        return m;
    endfunction
endpackage

// File: rtl/ecm_classify.sv
module ecm_classify
    import ecc_mark_pkg::*;
(
    input  cword_t          word_in,
    output word_class_e     cls,
    output logic [DW-1:0]   fixed_data
);
    logic [POSW-1:0] syn;

    always_comb begin
        syn = syndrome(word_in);
        cls = classify(word_in);
        fixed_data = word_in.data;
        for (int i = 0; i < DW; i++)
            if (syn == pos_of(i) && ^{word_in.data, word_in.chk})
                fixed_data[i] = ~word_in.data[i];
    end
endmodule

// File: rtl/ecm_rewrite.sv
module ecm_rewrite
    import ecc_mark_pkg::*;
(
    input  word_class_e     cls,
    input  cword_t          word_in,
    input  logic [DW-1:0]   fixed_data,
    input  logic [IDW-1:0]  mark_id,
    output cword_t          word_out
);
    always_comb begin
        unique case (cls)
            WC_CORR: begin
                word_out.data = fixed_data;
                word_out.chk  = ecc_gen(fixed_data);
            end
            WC_RAW:  word_out = mark_word(mark_id);
            default: word_out = word_in;
        endcase
    end
endmodule

// File: rtl/ecm_status.sv
module ecm_status (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);                                   // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !set_evt) |=> !flag);                    // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_evt) |=> flag);                        // R5
endmodule

// File: rtl/ecm_writeback_marker.sv
module ecm_writeback_marker
    import ecc_mark_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IDW-1:0]  mark_id_cfg,
    input  logic            raw_clr,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   in_data,
    input  logic [CW-1:0]   in_chk,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [DW-1:0]   out_data,
    output logic [CW-1:0]   out_chk,
    output logic            out_last,
    output logic            raw_err_flag
);
    cword_t         word_in, word_new, word_q;
    word_class_e    cls;
    logic [DW-1:0]  fixed_data;
    logic           line_start;
    logic [IDW-1:0] id_hold, id_use;
    logic           fire;

    assign word_in  = '{data: in_data, chk: in_chk};
    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign id_use   = line_start ? mark_id_cfg : id_hold;

    ecm_classify u_cls (
        .word_in    (word_in),
        .cls        (cls),
        .fixed_data (fixed_data)
    );

    ecm_rewrite u_rew (
        .cls        (cls),
        .word_in    (word_in),
        .fixed_data (fixed_data),
        .mark_id    (id_use),
        .word_out   (word_new)
    );

    ecm_status u_sts (
        .clk     (clk),
        .rst     (rst),
        .set_evt (fire && cls == WC_RAW),
        .clr_evt (raw_clr),
        .flag    (raw_err_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            word_q     <= '0;
            line_start <= 1'b1;
            id_hold    <= '0;
        end else if (fire) begin
            out_valid  <= 1'b1;
            out_last   <= in_last;
            word_q     <= word_new;
            line_start <= in_last;
            id_hold    <= id_use;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    assign out_data = word_q.data;
    assign out_chk  = word_q.chk;

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);                                           // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(word_q) && $stable(out_last))); // R7
    AST_OUT_CLEAN_OR_MARKED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (classify(word_q) == WC_CLEAN || classify(word_q) == WC_MARKED)); // R9
    AST_MARKED_PASS: assert property (@(posedge clk) disable iff (rst)
        (fire && cls == WC_MARKED) |=> (out_data == $past(in_data) && out_chk == $past(in_chk))); // R4
    AST_RAW_MARKED: assert property (@(posedge clk) disable iff (rst)
        (fire && cls == WC_RAW) |=> (out_data[DW-1:IDW] == MARK_SIG));     // R3
endmodule

// File: tb/tb_ecm_writeback_marker.sv
`timescale 1ns/1ps
module tb_ecm_writeback_marker;
    logic        clk = 0, rst = 1;
    logic [11:0] mark_id_cfg = 0;
    logic        raw_clr = 0, in_valid = 0, in_last = 0, out_ready = 1;
    logic [63:0] in_data = 0;
    logic [7:0]  in_chk = 0;
    logic        in_ready, out_valid, out_last, raw_err_flag;
    logic [63:0] out_data;
    logic [7:0]  out_chk;

    ecm_writeback_marker dut (.*);

    always #2.5 clk = ~clk;

    localparam logic [51:0] SIG = 52'hDEAD0BADF00D5;
    int n_chk = 0, n_bad = 0;
    bit done = 0, stall_mode = 0, flag_model = 0;
    int ptab[64];
    logic [63:0] q_d[$];
    logic [7:0]  q_c[$];
    logic        q_l[$];
    string       q_t[$];

    task automatic check(bit ok, string tag, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ben_enc(logic [63:0] d);
        logic [6:0] c = 0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= ptab[i][6:0];
        return {^{d, c}, c};
    endfunction

    task automatic push(logic [63:0] d, logic [7:0] c, bit last,
                        logic [63:0] ed, logic [7:0] ec, string tag);
        bit acc;
        q_d.push_back(ed); q_c.push_back(ec); q_l.push_back(last); q_t.push_back(tag);
        @(negedge clk);
        in_valid = 1; in_data = d; in_chk = c; in_last = last;
        #1 acc = in_ready;
        while (!acc) begin @(negedge clk); #1 acc = in_ready; end
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    // kind: 0 clean, 1 single flip, 2 double flip, 3 already marked
    task automatic send_word(int kind, logic [11:0] id, bit last, int fb);
        logic [63:0] d, ed; logic [7:0] c, ec; logic [71:0] v;
        int b1, b2;
        d = {$urandom, $urandom}; c = ben_enc(d);
        v = {c, d}; ed = d; ec = c;
        case (kind)
            1: begin b1 = (fb >= 0) ? fb : int'($urandom % 72); v[b1] = ~v[b1];
                push(v[63:0], v[71:64], last, ed, ec, "R2 single-bit correction"); end
            2: begin b1 = $urandom % 72; b2 = (b1 + 1 + ($urandom % 71)) % 72;
                v[b1] = ~v[b1]; v[b2] = ~v[b2];
                ed = {SIG, id}; ec = ben_enc(ed) ^ 8'h03; flag_model = 1;
                push(v[63:0], v[71:64], last, ed, ec, "R3 raw word marked"); end
            3: begin ed = {SIG, 12'($urandom)}; ec = ben_enc(ed) ^ 8'h03;
                push(ed, ec, last, ed, ec, "R4 marked pass-through"); end
            default: push(d, c, last, ed, ec, "R1 clean pass-through");
        endcase
    endtask

    task automatic drain();
        while (q_d.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: transfers compared at falling edge; stalls checked for stability
    initial begin
        logic [72:0] held; bit pend = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pend) begin
                    check(out_valid && {out_last, out_chk, out_data} == held,
                          "R7 stall hold", {out_chk, out_data}, held[71:0]);
                    pend = 0;
                end
                if (out_valid && out_ready) begin
                    if (q_d.size() == 0) check(0, "R7 unexpected output", {out_chk, out_data}, 0);
                    else begin
                        string t; logic [63:0] ed; logic [7:0] ec; logic el;
                        t = q_t.pop_front(); ed = q_d.pop_front(); ec = q_c.pop_front(); el = q_l.pop_front();
                        check(out_data == ed && out_chk == ec, t, {out_chk, out_data}, {ec, ed});
                        check(out_last == el, "R7 last flag", 72'(out_last), 72'(el));
                    end
                end else if (out_valid) begin
                    held = {out_last, out_chk, out_data}; pend = 1;
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p = 3, k = 0;
        void'($urandom(32'd20240611));
        while (k < 64) begin
            if ((p & (p - 1)) != 0) begin ptab[k] = p; k++; end
            p++;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!out_valid && !raw_err_flag && in_ready, "R8 reset state",
              {69'd0, out_valid, raw_err_flag, in_ready}, 72'd1);

        for (int i = 0; i < 8; i++) send_word(0, 0, i == 7, -1);        // R1
        for (int i = 0; i < 8; i++) send_word(1, 0, i == 7, i == 0 ? 71 : (i == 1 ? 64 : -1)); // R2
        drain();
        check(raw_err_flag == 0, "R5 no flag without raw", 72'(raw_err_flag), 0);

        // R6: ID sampled at line start, changed mid-line
        mark_id_cfg = 12'hA5C;
        send_word(2, 12'hA5C, 0, -1);
        mark_id_cfg = 12'h3F1;
        for (int i = 1; i < 8; i++) send_word(i % 2 ? 2 : 0, 12'hA5C, i == 7, -1);
        send_word(2, 12'h3F1, 1, -1);                                    // R6 next line new ID
        drain();
        check(raw_err_flag == 1, "R5 flag set by raw", 72'(raw_err_flag), 1);

        @(negedge clk); raw_clr = 1; @(negedge clk); raw_clr = 0; @(negedge clk);
        check(raw_err_flag == 0, "R5 flag cleared", 72'(raw_err_flag), 0);

        for (int i = 0; i < 8; i++) send_word(3, 0, i == 7, -1);        // R4
        drain();
        check(raw_err_flag == 0, "R4 marked leaves flag clear", 72'(raw_err_flag), 0);

        // R5: set beats clear in the same cycle
        @(negedge clk); raw_clr = 1;
        send_word(2, 12'h3F1, 1, -1);
        raw_clr = 0;
        drain();
        check(raw_err_flag == 1, "R5 set wins over clear", 72'(raw_err_flag), 1);
        @(negedge clk); raw_clr = 1; @(negedge clk); raw_clr = 0;

        // random lines with output stalls
        flag_model = 0; stall_mode = 1;
        for (int ln = 0; ln < 40; ln++) begin
            logic [11:0] id = 12'($urandom);
            mark_id_cfg = id;
            for (int i = 0; i < 8; i++) begin
                send_word($urandom % 4, id, i == 7, -1);
                mark_id_cfg = 12'($urandom);
            end
        end
        drain();
        stall_mode = 0;
        drain();
        check(raw_err_flag == flag_model, "R5 flag after random lines",
              72'(raw_err_flag), 72'(flag_model));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule